// File: doc/BRIEF.md
# Debounced status interrupt controller

This block watches two status signals from charger-detection logic and turns selected changes on them into a host interrupt. The bus-power-valid comparator output is first filtered: a new level must persist for a programmable number of clock cycles before it is accepted, so that connector bounce on insertion or removal gives one event, not many. Each accepted change, in either direction, is latched as a pending status bit. A second status bit latches when the stuck-contact timeout flag goes from 0 to 1. Other flags, such as the detection-running indication, are not inputs of this block and can never cause an interrupt.

The host sees the pending bits on a status port. A single-cycle read strobe stands for a read of the status register, and the pending bits clear on the clock edge that ends the strobe. A global enable gates the request pin without touching the pending bits, and a polarity control picks the active level. The pin is also given as an open-drain pull-down enable, for a pad that can only sink current.

Top module: `stat_irq_ctrl`

## Requirements
- R1: After reset, `stat_bits` is 2'b00 and `vbus_lvl` is 0; with `irq_en` and `irq_pol` at 0 the pin is inactive (`irq_level` = 1).
- R2: `vbus_lvl` takes a new value of `vbus_raw` only once `vbus_raw` has differed from `vbus_lvl` on DB_CYCLES consecutive rising clock edges; it changes on the DB_CYCLES-th such edge. Any shorter excursion leaves `vbus_lvl` and `stat_bits` unchanged.
- R3: Each accepted change of `vbus_lvl`, rising or falling, sets `stat_bits[0]` on the same edge.
- R4: A 0-to-1 change of `stuck_flag` sets `stat_bits[1]` on the edge that first samples it high; a flag held high or going low sets nothing.
- R5: A pending bit stays set until a read; with `stat_rd` high at a rising edge, every pending bit without a new event on that edge is 0 after it.
- R6: An event on the same edge as a read leaves its bit set after that edge.
- R7: With `irq_en` = 0 the pin is inactive whatever is pending, and the pending bits are kept.
- R8: The pin is active when `irq_en` = 1 and any status bit is set; the active level equals `irq_pol` (0 = active low, 1 = active high), the inactive level is its complement, and `irq_pull_low` = 1 exactly when `irq_level` = 0.
- R9: Raising `irq_en` while a bit is pending activates the pin in the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vbus_raw | input | 1 | Unfiltered bus-power-valid comparator output |
| stuck_flag | input | 1 | Stuck-contact timeout flag |
| irq_en | input | 1 | Global interrupt enable |
| irq_pol | input | 1 | Active level of the request pin |
| stat_rd | input | 1 | Status read strobe, clears pending bits |
| stat_bits | output | 2 | Pending events: bit 0 bus-valid change, bit 1 stuck-contact rise |
| vbus_lvl | output | 1 | Filtered bus-power-valid level |
| irq_level | output | 1 | Logic level of the request pin |
| irq_pull_low | output | 1 | Open-drain pull-down enable of the request pin |

## Verification
The collision that matters is a status read landing on the same edge as a new event: the filter accepting a bus-valid change, or the stuck flag rising. The bench places the read strobe on exactly the DB_CYCLES-th edge of a held detach, and separately raises the stuck flag together with the strobe while the other bit is pending. It then expects the colliding bit to survive and the other to be cleared, comparing the whole status word against a value built from the event timing.

// File: rtl/stat_irq_pkg.sv
// Shared indices and types for the status interrupt controller.
// Assumes two event sources; bit positions are visible on the status port.
package stat_irq_pkg;
    localparam int SRC_VBUS  = 0;
    localparam int SRC_STUCK = 1;
    localparam int NSRC      = 2;
    typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/stat_irq_deb.sv
// Level filter: accepts a new input level only after it has held for
// DB_CYCLES consecutive clocks. Input assumed already synchronous.
// flip_o pulses in the cycle whose edge updates level_o.
module stat_irq_deb #(
    parameter int DB_CYCLES = 30000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic level_o,
    output logic flip_o
);
    localparam int CNT_W = $clog2(DB_CYCLES) + 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DB_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             differ;

    // Flip when the differing level has reached its final count.
    assign differ = raw_i != level_o;
    assign flip_o = differ && (cnt_q == LAST);

    // Count held-different cycles; restart whenever input matches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            level_o <= 1'b0;
        end else if (!differ) begin
            cnt_q <= '0;
        end else if (flip_o) begin
            cnt_q   <= '0;
            level_o <= raw_i;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/stat_irq_rise.sv
// Rising-edge detector for a synchronous flag; reset treats the flag as 0.
module stat_irq_rise (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o
);
    logic prev_q;

    // Remember last sampled value of the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sig_i;
    end

    assign rise_o = sig_i && !prev_q;
endmodule

// File: rtl/stat_irq_pend.sv
// Pending-event register. A read clears bits; an event on the same edge
// as the read wins, so no event is lost.
module stat_irq_pend #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         clr_i,
    output logic [N-1:0] pend_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // Per-bit sticky latch with read clear.
        always_ff @(posedge clk) begin
            if (!rst_n)        pend_o[i] <= 1'b0;
            else if (set_i[i]) pend_o[i] <= 1'b1;
            else if (clr_i)    pend_o[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/stat_irq_pin.sv
// Request pin logic: combinational so that enable changes act at once.
module stat_irq_pin #(
    parameter int N = 2
) (
    input  logic [N-1:0] pend_i,
    input  logic         en_i,
    input  logic         pol_i,
    output logic         level_o,
    output logic         pull_low_o
);
    logic active;

    // Active only when enabled and something is pending.
    always_comb begin
        active     = en_i && (|pend_i);
        level_o    = active ? pol_i : !pol_i;
        pull_low_o = !level_o;
    end
endmodule

// File: rtl/stat_irq_ctrl.sv
// Top: filters the bus-valid level, detects stuck-flag rises, latches
// pending events and drives the request pin. Inputs assumed synchronous.
module stat_irq_ctrl
    import stat_irq_pkg::*;
#(
    parameter int DB_CYCLES = 30000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            vbus_raw,
    input  logic            stuck_flag,
    input  logic            irq_en,
    input  logic            irq_pol,
    input  logic            stat_rd,
    output logic [NSRC-1:0] stat_bits,
    output logic            vbus_lvl,
    output logic            irq_level,
    output logic            irq_pull_low
);
    logic     vbus_flip;
    logic     stuck_rise;
    src_vec_t evt;

    stat_irq_deb #(.DB_CYCLES(DB_CYCLES)) deb_i (
        .clk(clk), .rst_n(rst_n), .raw_i(vbus_raw),
        .level_o(vbus_lvl), .flip_o(vbus_flip)
    );

    stat_irq_rise rise_i (
        .clk(clk), .rst_n(rst_n), .sig_i(stuck_flag), .rise_o(stuck_rise)
    );

    // Gather event pulses into source order.
    always_comb begin
        evt            = '0;
        evt[SRC_VBUS]  = vbus_flip;
        evt[SRC_STUCK] = stuck_rise;
    end

    stat_irq_pend #(.N(NSRC)) pend_i (
        .clk(clk), .rst_n(rst_n), .set_i(evt), .clr_i(stat_rd),
        .pend_o(stat_bits)
    );

    stat_irq_pin #(.N(NSRC)) pin_i (
        .pend_i(stat_bits), .en_i(irq_en), .pol_i(irq_pol),
        .level_o(irq_level), .pull_low_o(irq_pull_low)
    );
endmodule

// File: rtl/stat_irq_ctrl_chk.sv
// Property checker for stat_irq_ctrl, attached by bind.
module stat_irq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       vbus_raw,
    input logic       stuck_flag,
    input logic       irq_en,
    input logic       irq_pol,
    input logic       stat_rd,
    input logic [1:0] stat_bits,
    input logic       vbus_lvl,
    input logic       irq_level,
    input logic       irq_pull_low,
    input logic       vbus_flip,
    input logic       stuck_rise
);
    p_lvl_from_raw_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vbus_lvl) |-> ($past(vbus_raw) == vbus_lvl));

    p_change_pends_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vbus_lvl) |-> stat_bits[0]);

    p_stuck_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stuck_flag) |=> stat_bits[1]);

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_bits[1] && !stat_rd) |=> stat_bits[1]);

    p_read_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !stuck_rise) |=> !stat_bits[1]);

    p_collide_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && vbus_flip) |=> stat_bits[0]);

    p_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> (irq_level == !irq_pol));

    p_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && (stat_bits != 2'b00)) |-> (irq_level == irq_pol));

    p_open_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pull_low != irq_level);
endmodule

bind stat_irq_ctrl stat_irq_ctrl_chk chk_i (
    .clk(clk), .rst_n(rst_n), .vbus_raw(vbus_raw), .stuck_flag(stuck_flag),
    .irq_en(irq_en), .irq_pol(irq_pol), .stat_rd(stat_rd),
    .stat_bits(stat_bits), .vbus_lvl(vbus_lvl), .irq_level(irq_level),
    .irq_pull_low(irq_pull_low), .vbus_flip(vbus_flip),
    .stuck_rise(stuck_rise)
);

// File: tb/stat_irq_ctrl_tb_top.sv
// Self-checking bench for stat_irq_ctrl with a short filter window.
module stat_irq_ctrl_tb_top;
    localparam int CLK_P = 10;
    localparam int DB    = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vbus_raw = 1'b0;
    logic       stuck_flag = 1'b0;
    logic       irq_en = 1'b0;
    logic       irq_pol = 1'b0;
    logic       stat_rd = 1'b0;
    logic [1:0] stat_bits;
    logic       vbus_lvl;
    logic       irq_level;
    logic       irq_pull_low;

    int checks = 0;
    int errors = 0;

    stat_irq_ctrl #(.DB_CYCLES(DB)) dut_i (
        .clk(clk), .rst_n(rst_n), .vbus_raw(vbus_raw),
        .stuck_flag(stuck_flag), .irq_en(irq_en), .irq_pol(irq_pol),
        .stat_rd(stat_rd), .stat_bits(stat_bits), .vbus_lvl(vbus_lvl),
        .irq_level(irq_level), .irq_pull_low(irq_pull_low)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_read;
        stat_rd = 1'b1;
        tick(1);
        stat_rd = 1'b0;
    endtask

    initial begin
        #(CLK_P * 100000);
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        // R1 reset state
        check(stat_bits, 0, "R1 status");
        check(vbus_lvl, 0, "R1 level");
        check(irq_level, 1, "R1 pin");

        // R2 glitches of every length below the window
        for (int g = 1; g < DB; g++) begin
            vbus_raw = 1'b1;
            tick(g);
            vbus_raw = 1'b0;
            tick(DB + 2);
            check(vbus_lvl, 0, "R2 glitch level");
            check(stat_bits, 0, "R2 glitch status");
        end

        // R2/R3 attach held exactly the window
        vbus_raw = 1'b1;
        tick(DB - 1);
        check(vbus_lvl, 0, "R2 one edge early");
        check(stat_bits, 0, "R3 not yet");
        tick(1);
        check(vbus_lvl, 1, "R2 accepted");
        check(stat_bits, 1, "R3 rise event");

        // R7/R8 every enable/polarity combination with an event pending
        for (int e = 0; e < 2; e++) begin
            for (int p = 0; p < 2; p++) begin
                irq_en = 1'(e);
                irq_pol = 1'(p);
                #1;
                check(irq_level, (e == 1) ? p : 1 - p, "R8 pin level");
                check(irq_pull_low, (irq_level == 1'b0) ? 1 : 0, "R8 pull");
            end
        end
        irq_en = 1'b0;
        irq_pol = 1'b0;
        tick(3);
        check(irq_level, 1, "R7 masked");
        check(stat_bits, 1, "R7 kept");
        // R9 immediate reassert
        irq_en = 1'b1;
        #1;
        check(irq_level, 0, "R9 reassert");
        check(irq_pull_low, 1, "R9 pull");

        // R5 read clears
        tick(2);
        check(stat_bits, 1, "R5 held");
        do_read();
        check(stat_bits, 0, "R5 cleared");
        check(irq_level, 1, "R8 idle after read");

        // R3 detach is also an event
        vbus_raw = 1'b0;
        tick(DB);
        check(vbus_lvl, 0, "R2 detach level");
        check(stat_bits, 1, "R3 fall event");
        do_read();

        // R4 stuck flag
        stuck_flag = 1'b1;
        tick(1);
        check(stat_bits, 2, "R4 rise");
        tick(3);
        check(stat_bits, 2, "R5 stuck held");
        do_read();
        check(stat_bits, 0, "R5 stuck cleared");
        tick(4);
        check(stat_bits, 0, "R4 held high");
        stuck_flag = 1'b0;
        tick(3);
        check(stat_bits, 0, "R4 fall");

        // R6 stuck rise on the read edge
        vbus_raw = 1'b1;
        tick(DB);
        check(stat_bits, 1, "R3 setup");
        stuck_flag = 1'b1;
        stat_rd = 1'b1;
        tick(1);
        stat_rd = 1'b0;
        check(stat_bits, 2, "R6 stuck collide");

        // R6 filter acceptance on the read edge
        vbus_raw = 1'b0;
        tick(DB - 1);
        stat_rd = 1'b1;
        tick(1);
        stat_rd = 1'b0;
        check(vbus_lvl, 0, "R2 collide level");
        check(stat_bits, 1, "R6 vbus collide");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule